// File: doc/BRIEF.md
# Address-Range Memory Firewall with Indirect Rule Table

This block guards the ports of a multi-port memory controller. It keeps a table of twenty protection rules. Each rule names a range of 1 MiB address blocks, a range of transaction IDs, a set of ports, which security worlds it applies to, and whether a match is accepted or rejected. Each incoming request brings an address, a port number, a transaction ID and a secure flag. The block compares the request with every rule in the same cycle and returns one accept-or-reject decision.

Software never writes the table directly. It fills three staging words: the address bounds, the ID bounds and the rule attributes. It then writes a command word. The command word holds a rule index and one of two action bits. The commit action copies the staging words into the selected rule. The fetch action copies the selected rule back into the staging words, where software can read it. A separate default word holds one bit per port. This bit decides the outcome for a request that no valid rule matches.

Requests use a valid/ready handshake. A small controller has two states. In `ST_IDLE` the block is ready for a request. On transition *accept* (`chk_valid` high in `ST_IDLE`) it stores the decision and moves to `ST_RESP`. In `ST_RESP` it presents the decision. On transition *release* (`resp_ready` high in `ST_RESP`) it returns to `ST_IDLE`. While a response is pending, `ST_RESP` keeps itself and its decision unchanged.

Top module: `prot_rule_firewall`

## Requirements
- R1: After reset every rule is invalid, the default word is zero, all staging words read as zero, and every request is accepted.
- R2: Writing the command word (select 0) with bit 5 set and a rule index in bits [4:0] copies the staging words into that rule. An index of 20 or above leaves the table unchanged.
- R3: Writing the command word with bit 6 set (bit 5 clear) and a valid index loads that rule into the staging words by the next clock edge. The staging layouts are fixed. The address word (select 1) holds the low bound in [11:0] and the high bound in [23:12]. The ID word (select 2) uses the same two fields. The attribute word (select 3) holds the security field in [1:0], the valid flag in bit 2, the port mask in [12:3] and the reject flag in bit 13.
- R4: A rule covers a request only when address bits [31:20] lie between the low and high bounds, both ends included. Address bits [19:0] have no effect.
- R5: A rule covers a request only when the transaction ID lies between the ID low and high bounds, both ends included.
- R6: A rule covers a request only when the mask bit for the request's port (0 to 9) is set.
- R7: Security field bit 0 admits secure requests and bit 1 admits non-secure requests. A request whose world is not admitted does not match.
- R8: A matching rule with reject flag 0 accepts the request and one with reject flag 1 rejects it. When several rules match, the lowest-numbered one decides.
- R9: When no valid rule matches, bit p of the default word (select 4, bits [9:0]) decides for port p: 1 rejects and 0 accepts.
- R10: Committing all-zero staging words invalidates a rule. After all twenty rules are cleared this way, only the default word decides.
- R11: The decision appears on `resp_valid` in the cycle after the request is accepted. It stays unchanged until `resp_ready` is high. `chk_ready` is low while a response is pending.
- R12: A commit made in the same cycle as an accepted request does not affect that request's decision. It affects the requests that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Word select: 0 command, 1 address, 2 ID, 3 attributes, 4 default |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected word (combinational) |
| chk_valid | input | 1 | Request valid |
| chk_ready | output | 1 | Block can take a request |
| chk_addr | input | 32 | Request byte address |
| chk_port | input | 4 | Request port number |
| chk_id | input | 12 | Request transaction ID |
| chk_secure | input | 1 | 1 = secure request, 0 = non-secure |
| resp_valid | output | 1 | Decision valid |
| resp_ready | input | 1 | Consumer takes the decision |
| resp_reject | output | 1 | 1 = reject, 0 = accept |

## Verification
The assertions assume a few things about the inputs. Reset is applied before the first request. Port numbers stay below ten. There is at most one configuration write per cycle, so a fetch and a staging write never collide. The bench keeps to these assumptions: it sweeps only ports 0 to 9, issues configuration writes one at a time, and changes every input half a cycle away from the sampling edge. It holds `resp_ready` high except in the deliberate stall test. That keeps requests back to back, so a commit can land in the same cycle as an accepted request.

// File: rtl/fw_pkg.sv
package fw_pkg;
    localparam int BND_W      = 12;
    localparam int ID_W       = 12;
    localparam int NPORT      = 10;
    localparam int PORT_IDX_W = $clog2(NPORT);
    localparam int COMMIT_BIT = 5;
    localparam int FETCH_BIT  = 6;

    typedef enum logic [2:0] {
        SEL_CMD  = 3'd0,
        SEL_ADDR = 3'd1,
        SEL_ID   = 3'd2,
        SEL_DATA = 3'd3,
        SEL_DFLT = 3'd4
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fw_state_e;

    typedef struct packed {
        logic [BND_W-1:0] hi;
        logic [BND_W-1:0] lo;
    } mb_bounds_t;

    typedef struct packed {
        logic [ID_W-1:0] hi;
        logic [ID_W-1:0] lo;
    } id_bounds_t;

    typedef struct packed {
        logic             rej;
        logic [NPORT-1:0] pmask;
        logic             valid;
        logic [1:0]       sec;
    } rule_attr_t;

    typedef struct packed {
        mb_bounds_t mb;
        id_bounds_t id;
        rule_attr_t attr;
    } rule_t;
endpackage

// File: rtl/fw_rule_match.sv
module fw_rule_match
    import fw_pkg::*;
(
    input  rule_t                 rule,
    input  logic [BND_W-1:0]      req_mb,
    input  logic [ID_W-1:0]       req_id,
    input  logic [PORT_IDX_W-1:0] req_port,
    input  logic                  req_secure,
    output logic                  hit
);
    logic port_ok;
    logic sec_ok;
    logic mb_ok;
    logic id_ok;

    always_comb begin
        port_ok = 1'b0;
        if (req_port < PORT_IDX_W'(NPORT)) begin
            port_ok = rule.attr.pmask[req_port];
        end
        sec_ok = req_secure ? rule.attr.sec[0] : rule.attr.sec[1];
        mb_ok  = (req_mb >= rule.mb.lo) && (req_mb <= rule.mb.hi);
        id_ok  = (req_id >= rule.id.lo) && (req_id <= rule.id.hi);
        hit    = rule.attr.valid && port_ok && sec_ok && mb_ok && id_ok;
    end
endmodule

// File: rtl/fw_rule_bank.sv
module fw_rule_bank
    import fw_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int IDX_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_go,
    input  logic [IDX_W-1:0]      rule_idx,
    input  rule_t                 wr_rule,
    input  logic [IDX_W-1:0]      rd_idx,
    output rule_t                 rd_rule,
    input  logic [BND_W-1:0]      req_mb,
    input  logic [ID_W-1:0]       req_id,
    input  logic [PORT_IDX_W-1:0] req_port,
    input  logic                  req_secure,
    output logic [NUM_RULES-1:0]  hits,
    output logic [NUM_RULES-1:0]  rejs
);
    rule_t table_q [NUM_RULES];

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                table_q[g] <= '0;
            end else if (commit_go && (rule_idx == IDX_W'(g))) begin
                table_q[g] <= wr_rule;
            end
        end

        fw_rule_match u_match (
            .rule       (table_q[g]),
            .req_mb     (req_mb),
            .req_id     (req_id),
            .req_port   (req_port),
            .req_secure (req_secure),
            .hit        (hits[g])
        );

        assign rejs[g] = table_q[g].attr.rej;

        // R10: an all-zero commit leaves the rule unable to match
        a_r10_zero_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_go && rule_idx == IDX_W'(g) && wr_rule == '0) |=> !hits[g]);
    end

    always_comb begin
        rd_rule = '0;
        for (int i = 0; i < NUM_RULES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_rule = table_q[i];
            end
        end
    end
endmodule

// File: rtl/fw_stage.sv
module fw_stage
    import fw_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             commit_go,
    output logic             fetch_go,
    output logic [IDX_W-1:0] rule_idx,
    output rule_t            staged,
    input  rule_t            fetched,
    output logic [NPORT-1:0] dflt
);
    localparam int MB_W   = $bits(mb_bounds_t);
    localparam int IDB_W  = $bits(id_bounds_t);
    localparam int ATTR_W = $bits(rule_attr_t);

    mb_bounds_t       stage_mb;
    id_bounds_t       stage_id;
    rule_attr_t       stage_attr;
    logic [IDX_W-1:0] cmd_q;
    logic [NPORT-1:0] dflt_q;
    logic             cmd_wr;
    logic             idx_ok;
    cfg_sel_e         sel;

    always_comb begin
        sel       = cfg_sel_e'(cfg_sel);
        rule_idx  = cfg_wdata[IDX_W-1:0];
        idx_ok    = rule_idx < IDX_W'(NUM_RULES);
        cmd_wr    = cfg_wr && (sel == SEL_CMD);
        commit_go = cmd_wr && idx_ok && cfg_wdata[COMMIT_BIT];
        fetch_go  = cmd_wr && idx_ok && cfg_wdata[FETCH_BIT] && !cfg_wdata[COMMIT_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_mb   <= '0;
            stage_id   <= '0;
            stage_attr <= '0;
            cmd_q      <= '0;
            dflt_q     <= '0;
        end else if (fetch_go) begin
            stage_mb   <= fetched.mb;
            stage_id   <= fetched.id;
            stage_attr <= fetched.attr;
            cmd_q      <= rule_idx;
        end else if (cfg_wr) begin
            unique case (sel)
                SEL_CMD:  cmd_q      <= rule_idx;
                SEL_ADDR: stage_mb   <= mb_bounds_t'(cfg_wdata[MB_W-1:0]);
                SEL_ID:   stage_id   <= id_bounds_t'(cfg_wdata[IDB_W-1:0]);
                SEL_DATA: stage_attr <= rule_attr_t'(cfg_wdata[ATTR_W-1:0]);
                SEL_DFLT: dflt_q     <= cfg_wdata[NPORT-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (sel)
            SEL_CMD:  cfg_rdata[IDX_W-1:0]  = cmd_q;
            SEL_ADDR: cfg_rdata[MB_W-1:0]   = stage_mb;
            SEL_ID:   cfg_rdata[IDB_W-1:0]  = stage_id;
            SEL_DATA: cfg_rdata[ATTR_W-1:0] = stage_attr;
            SEL_DFLT: cfg_rdata[NPORT-1:0]  = dflt_q;
            default:  cfg_rdata = '0;
        endcase
    end

    assign staged = '{mb: stage_mb, id: stage_id, attr: stage_attr};
    assign dflt   = dflt_q;

    // R3: a fetch places the selected rule in the staging words at the next edge
    a_r3_fetch_loads_stage: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> (staged == $past(fetched)));
endmodule

// File: rtl/prot_rule_firewall.sv
module prot_rule_firewall
    import fw_pkg::*;
#(
    parameter int NUM_RULES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        chk_valid,
    output logic        chk_ready,
    input  logic [31:0] chk_addr,
    input  logic [3:0]  chk_port,
    input  logic [11:0] chk_id,
    input  logic        chk_secure,
    output logic        resp_valid,
    input  logic        resp_ready,
    output logic        resp_reject
);
    localparam int IDX_W = $clog2(NUM_RULES);

    logic                  commit_go;
    logic                  fetch_go;
    logic [IDX_W-1:0]      rule_idx;
    rule_t                 staged;
    rule_t                 fetched;
    logic [NPORT-1:0]      dflt;
    logic [NUM_RULES-1:0]  hits;
    logic [NUM_RULES-1:0]  rejs;
    logic [NUM_RULES-1:0]  win;
    logic                  dflt_rej;
    logic                  reject_now;
    logic                  rej_q;
    fw_state_e             state_q;
    fw_state_e             state_d;
    logic                  take;

    fw_stage #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .commit_go (commit_go),
        .fetch_go  (fetch_go),
        .rule_idx  (rule_idx),
        .staged    (staged),
        .fetched   (fetched),
        .dflt      (dflt)
    );

    fw_rule_bank #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_go  (commit_go),
        .rule_idx   (rule_idx),
        .wr_rule    (staged),
        .rd_idx     (rule_idx),
        .rd_rule    (fetched),
        .req_mb     (chk_addr[31:32-BND_W]),
        .req_id     (chk_id),
        .req_port   (chk_port[PORT_IDX_W-1:0]),
        .req_secure (chk_secure),
        .hits       (hits),
        .rejs       (rejs)
    );

    // lowest-numbered hit wins
    always_comb begin
        win = '0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                win    = '0;
                win[i] = 1'b1;
            end
        end
        dflt_rej = 1'b1;
        if (chk_port < 4'(NPORT)) begin
            dflt_rej = dflt[chk_port];
        end
        reject_now = (|hits) ? (|(win & rejs)) : dflt_rej;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (chk_valid)  state_d = ST_RESP;
            ST_RESP: if (resp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_comb begin
        chk_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_RESP);
        take       = chk_valid && chk_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej_q <= 1'b0;
        end else if (take) begin
            rej_q <= reject_now;
        end
    end

    assign resp_reject = rej_q;

    // R8: priority selection never names more than one rule
    a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));
    // R11: accepted request yields a response next cycle
    a_r11_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_ready) |=> resp_valid);
    // R11: a stalled response holds its decision
    a_r11_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_reject)));
    // R11: no new request while a response is pending
    a_r11_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !chk_ready);
endmodule

// File: tb/prot_rule_firewall_bench.sv
module prot_rule_firewall_bench;
    localparam int NR = 20;
    localparam int NP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        chk_valid = 1'b0;
    logic        chk_ready;
    logic [31:0] chk_addr = '0;
    logic [3:0]  chk_port = '0;
    logic [11:0] chk_id = '0;
    logic        chk_secure = 1'b0;
    logic        resp_valid;
    logic        resp_ready = 1'b1;
    logic        resp_reject;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int        m_lo [NR];
    int        m_hi [NR];
    int        m_il [NR];
    int        m_ih [NR];
    bit [1:0]  m_sec [NR];
    bit        m_val [NR];
    bit [9:0]  m_mask [NR];
    bit        m_rej [NR];
    bit [9:0]  m_dflt;

    prot_rule_firewall u_prot_rule_firewall (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chk_valid(chk_valid),
        .chk_ready(chk_ready), .chk_addr(chk_addr), .chk_port(chk_port),
        .chk_id(chk_id), .chk_secure(chk_secure), .resp_valid(resp_valid),
        .resp_ready(resp_ready), .resp_reject(resp_reject)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic stage_rule(int lo, int hi, int il, int ih, bit [1:0] sec,
                              bit v, bit [9:0] mask, bit rej);
        cfg_write(3'd1, 32'((hi << 12) | lo));
        cfg_write(3'd2, 32'((ih << 12) | il));
        cfg_write(3'd3, {18'd0, rej, mask, v, sec});
    endtask

    task automatic model_set(int idx, int lo, int hi, int il, int ih, bit [1:0] sec,
                             bit v, bit [9:0] mask, bit rej);
        if (idx < NR) begin
            m_lo[idx] = lo; m_hi[idx] = hi; m_il[idx] = il; m_ih[idx] = ih;
            m_sec[idx] = sec; m_val[idx] = v; m_mask[idx] = mask; m_rej[idx] = rej;
        end
    endtask

    task automatic put_rule(int idx, int lo, int hi, int il, int ih, bit [1:0] sec,
                            bit v, bit [9:0] mask, bit rej);
        stage_rule(lo, hi, il, ih, sec, v, mask, rej);
        cfg_write(3'd0, 32'(idx) | 32'h20);
        model_set(idx, lo, hi, il, ih, sec, v, mask, rej);
    endtask

    function automatic bit expect_rej(int mb, int port, int id, bit sec);
        for (int r = 0; r < NR; r++) begin
            if (m_val[r] && m_mask[r][port] && mb >= m_lo[r] && mb <= m_hi[r] &&
                id >= m_il[r] && id <= m_ih[r] && (sec ? m_sec[r][0] : m_sec[r][1]))
                return m_rej[r];
        end
        return m_dflt[port];
    endfunction

    task automatic txn(int mb, int port, int id, bit sec, output bit rej);
        @(negedge clk);
        chk_valid = 1'b1;
        chk_addr = {mb[11:0], 20'hA5C3E};
        chk_port = port[3:0]; chk_id = id[11:0]; chk_secure = sec;
        @(posedge clk);
        @(negedge clk);
        chk_valid = 1'b0;
        check("R11 resp_valid after accept", {31'd0, resp_valid}, 32'd1);
        rej = resp_reject;
    endtask

    task automatic txn_check(string req, int mb, int port, int id, bit sec);
        bit r;
        txn(mb, port, id, sec, r);
        check(req, {31'd0, r}, {31'd0, expect_rej(mb, port, id, sec)});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        bit r;
        for (int i = 0; i < NR; i++) model_set(i, 0, 0, 0, 0, 2'd0, 1'b0, 10'd0, 1'b0);
        m_dflt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        cfg_read(3'd1, d); check("R1 addr stage", d, 0);
        cfg_read(3'd2, d); check("R1 id stage", d, 0);
        cfg_read(3'd3, d); check("R1 data stage", d, 0);
        cfg_read(3'd4, d); check("R1 default", d, 0);
        cfg_write(3'd0, 32'h45);
        cfg_read(3'd3, d); check("R1 rule5 invalid", d, 0);
        txn(3, 9, 7, 1'b0, r); check("R1 accept all", {31'd0, r}, 0);
        txn(4095, 0, 4095, 1'b1, r); check("R1 accept all", {31'd0, r}, 0);

        // program a small rule set
        put_rule(0, 2, 3, 0, 4095, 2'd3, 1'b1, 10'h3FF, 1'b1);
        put_rule(1, 0, 7, 16, 31, 2'd1, 1'b1, 10'h00F, 1'b0);
        put_rule(2, 4, 5, 0, 4095, 2'd2, 1'b1, 10'h3F0, 1'b1);
        put_rule(19, 8, 8, 0, 15, 2'd3, 1'b1, 10'h200, 1'b1);
        cfg_write(3'd4, 32'h2AA); m_dflt = 10'h2AA;

        // R3: readback of rule 1 after staging was left holding rule 19
        cfg_write(3'd0, 32'h41);
        cfg_read(3'd1, d); check("R3 addr fields", d, 32'h007000);
        cfg_read(3'd2, d); check("R3 id fields", d, 32'h01F010);
        cfg_read(3'd3, d); check("R3 data fields", d, {18'd0, 1'b0, 10'h00F, 1'b1, 2'd1});
        cfg_read(3'd0, d); check("R3 command index", d, 32'd1);

        // R2: out-of-range index ignored
        put_rule(25, 0, 4095, 0, 4095, 2'd3, 1'b1, 10'h3FF, 1'b1);
        txn_check("R2 index 25 ignored", 9, 0, 100, 1'b1);
        txn_check("R2 index 25 ignored", 12, 4, 2000, 1'b0);

        // R4/R5/R6/R7/R8/R9 sweep
        for (int mb = 0; mb < 10; mb++)
            for (int p = 0; p < NP; p++)
                foreach (m_dflt[k]) if (k < 6) begin
                    int ids [6] = '{0, 15, 16, 31, 32, 4095};
                    for (int s = 0; s < 2; s++)
                        txn_check("R4/R5/R6/R7/R8/R9 sweep", mb, p, ids[k], s[0]);
                end

        // R11: stall holds the decision
        resp_ready = 1'b0;
        txn(2, 1, 5, 1'b1, r);
        check("R11 stalled reject", {31'd0, r}, 1);
        repeat (3) begin
            @(negedge clk);
            check("R11 hold valid", {31'd0, resp_valid}, 1);
            check("R11 hold value", {31'd0, resp_reject}, 1);
            check("R11 ready low", {31'd0, chk_ready}, 0);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        check("R11 released", {31'd0, resp_valid}, 0);
        check("R11 ready back", {31'd0, chk_ready}, 1);

        // R12: commit in the same cycle as an accepted request
        stage_rule(20, 20, 0, 4095, 2'd3, 1'b1, 10'h3FF, 1'b1);
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = {12'd20, 20'h0}; chk_port = 4'd2;
        chk_id = 12'd9; chk_secure = 1'b1;
        cfg_wr = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h23;
        @(posedge clk);
        @(negedge clk);
        chk_valid = 1'b0; cfg_wr = 1'b0;
        check("R12 old table used", {31'd0, resp_reject}, 0);
        model_set(3, 20, 20, 0, 4095, 2'd3, 1'b1, 10'h3FF, 1'b1);
        txn_check("R12 new rule later", 20, 2, 9, 1'b1);

        // R10: clear rule 0 by zero commit, then clear all
        put_rule(0, 0, 0, 0, 0, 2'd0, 1'b0, 10'd0, 1'b0);
        cfg_write(3'd0, 32'h40);
        cfg_read(3'd3, d); check("R10 rule0 data zero", d, 0);
        txn_check("R10 rule0 gone", 2, 0, 100, 1'b1);
        txn_check("R10 rule0 gone", 3, 5, 100, 1'b0);
        for (int i = 0; i < NR; i++) put_rule(i, 0, 0, 0, 0, 2'd0, 1'b0, 10'd0, 1'b0);
        for (int mb = 0; mb < 21; mb += 4)
            for (int p = 0; p < NP; p++) begin
                bit rr;
                txn(mb, p, 20, p[0], rr);
                check("R10 default only", {31'd0, rr}, {31'd0, m_dflt[p]});
            end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule